// File: doc/BRIEF.md
# Flash Byte-Program Controller with Polling

This block sits between a parallel programming interface and the code flash array of a small controller. When programming is enabled, a rising edge on the program strobe captures the address and data pins. The block then runs one self-timed operation: a byte write, a full chip erase or the setting of one protection bit. A ready/busy output shows when the operation is in progress. An array read made during that time returns a polling byte whose top bit is the inverse of the byte being written. When the operation ends, reads return the stored contents again.

The flash array lies outside the block and is reached through a simple memory port with a combinational read and a clocked write. A byte write can only clear bits: the block stores the old contents ANDed with the new data, so a byte that is not blank needs a chip erase before it can take a new value. Three protection bits set how much of the interface stays usable, at four levels. The same pins also give access to three read-only identification bytes.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A rising edge on `progStrobe` with `progEn` high, while ready and with an accepted operation, drives `readyBusy` low from the next cycle for exactly WRITE_CYCLES cycles. The operation codes on `opSel` are 0 array read, 1 byte program, 2 chip erase, 3 protection-bit program and 4 identification read.
- R2: A byte program stores (old byte AND data) at the captured address.
- R3: While busy, an array read (opSel 0) returns the captured data with bit 7 inverted and bits 6..0 unchanged. For a chip erase the captured data counts as FFH, so bit 7 reads 0.
- R4: Once ready, an array read returns the stored byte at `addr`.
- R5: A strobe edge that arrives while busy, or while `progEn` is low, is ignored. Nothing is captured and the busy period is not extended.
- R6: A chip erase sets every array byte to FFH and clears all three protection bits.
- R7: An identification read (opSel 4) returns 1EH at address 30H and 51H at address 31H. At address 32H it returns FFH when `lvMode` is 0 and 05H when it is 1. Any other address returns FFH. These bytes can be read at every protection level.
- R8: A protection-bit program with addr[1:0] = 1, 2 or 3 sets bit A, B or C. A value of 0 sets nothing. `lockLevel` is 4 when A, B and C are all set, 3 when A and B are set, 2 when A is set, and 1 otherwise.
- R9: At level 2 or above, `tableReadBlock` and `eaLatchEn` are high and byte-program strobes are ignored: no busy period and no write.
- R10: At level 3 or above, array reads made while ready return FFH.
- R11: At level 4, `extExecBlock` is high.
- R12: After reset the block is ready, all protection bits are clear and `lockLevel` is 1.
- R13: With opSel 1, 2, 3 or 5 to 7, `dataOut` is FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progEn | input | 1 | Programming-enable qualifier |
| lvMode | input | 1 | Identification variant: 1 selects low-voltage enable |
| opSel | input | 3 | Operation code |
| addr | input | ADDR_W | Address pins |
| dataIn | input | 8 | Data pins in |
| progStrobe | input | 1 | Program pulse |
| dataOut | output | 8 | Read data / polling byte |
| readyBusy | output | 1 | 1 ready, 0 busy |
| lockLevel | output | 3 | Protection level 1..4 |
| tableReadBlock | output | 1 | Table reads into internal memory from external code are blocked |
| eaLatchEn | output | 1 | External-access pin is latched at reset |
| extExecBlock | output | 1 | Execution from external memory is disabled |
| memAddr | output | ADDR_W | Array address |
| memRdData | input | 8 | Array read data (combinational) |
| memWrData | output | 8 | Array write data |
| memWrEn | output | 1 | Array byte write |
| memEraseAll | output | 1 | Array full erase |

## Verification
The bench builds the block with ADDR_W = 6 and WRITE_CYCLES = 6. The 64-byte array then holds the identification addresses, and every byte can be programmed twice, so the AND rule applies to all of them. The short busy time makes it possible to count each busy period cycle by cycle and to poll in every busy cycle. It also leaves room to drop a second strobe into the middle of an operation and to step through all four protection levels and back through an erase.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_ERASE = 3'd2;
  localparam logic [2:0] OP_LOCK  = 3'd3;
  localparam logic [2:0] OP_SIG   = 3'd4;

  localparam logic [7:0] ID_MAKER  = 8'h1E;
  localparam logic [7:0] ID_DEVICE = 8'h51;
  localparam logic [7:0] ID_HV     = 8'hFF;
  localparam logic [7:0] ID_LV     = 8'h05;

  typedef struct packed {
    logic latch;        // capture address/data pins
    logic latchErase;   // captured operation is an erase
    logic commitByte;   // perform the byte write
    logic commitErase;  // perform the chip erase
    logic commitLock;   // set the addressed protection bit
    logic busy;         // operation in progress
  } fpcStrobe_t;

endpackage

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
#(
  parameter int WRITE_CYCLES = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progStrobe,
  input  logic       progEn,
  input  logic [2:0] opSel,
  input  logic       progLocked,
  output fpcStrobe_t strb
);

  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_WAIT} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       opReg;
  logic             strobePrev;
  logic             rise;
  logic             opValid;
  logic             accept;

  assign rise    = progStrobe && !strobePrev;
  assign opValid = (opSel == OP_PROG && !progLocked) || opSel == OP_ERASE || opSel == OP_LOCK;
  assign accept  = rise && progEn && (state == ST_IDLE) && opValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      opReg      <= OP_READ;
      strobePrev <= 1'b0;
    end else begin
      strobePrev <= progStrobe;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_COMMIT;
            cnt   <= CNT_TOP;
            opReg <= opSel;
          end
        end
        default: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
          end else begin
            cnt   <= cnt - 1'b1;
            state <= ST_WAIT;
          end
        end
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.latch       = accept;
    strb.latchErase  = (opSel == OP_ERASE);
    strb.busy        = (state != ST_IDLE);
    strb.commitByte  = (state == ST_COMMIT) && (opReg == OP_PROG);
    strb.commitErase = (state == ST_COMMIT) && (opReg == OP_ERASE);
    strb.commitLock  = (state == ST_COMMIT) && (opReg == OP_LOCK);
  end

  // R1: the counter never leaves its window
  assert_cnt_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_TOP);

  // R1: an accepted edge always starts with the commit cycle
  assert_commit_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (state == ST_COMMIT));

  // R5: the held operation does not change while busy
  assert_op_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(opReg));

endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcStrobe_t        strb,
  input  logic [2:0]        opSel,
  input  logic              lvMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWrEn,
  output logic              memEraseAll,
  output logic [7:0]        dataOut,
  output logic [2:0]        lockQ
);

  localparam int LOCK_N = 3;

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              verifyBlock;
  logic [7:0]        pollByte;
  logic [7:0]        idByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= 8'hFF;
    end else if (strb.latch) begin
      addrQ <= addr;
      dataQ <= strb.latchErase ? 8'hFF : dataIn;
    end
  end

  for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rstN || strb.commitErase) begin
        lockQ[i] <= 1'b0;
      end else if (strb.commitLock && addrQ[1:0] == 2'(i + 1)) begin
        lockQ[i] <= 1'b1;
      end
    end
  end

  assign memAddr     = strb.busy ? addrQ : addr;
  assign memWrEn     = strb.commitByte;
  assign memWrData   = memRdData & dataQ;
  assign memEraseAll = strb.commitErase;

  assign verifyBlock = lockQ[0] && lockQ[1];
  assign pollByte    = {~dataQ[7], dataQ[6:0]};

  always_comb begin
    if (addr == ADDR_W'(8'h30))      idByte = ID_MAKER;
    else if (addr == ADDR_W'(8'h31)) idByte = ID_DEVICE;
    else if (addr == ADDR_W'(8'h32)) idByte = lvMode ? ID_LV : ID_HV;
    else                             idByte = 8'hFF;
  end

  always_comb begin
    if (opSel == OP_SIG)            dataOut = idByte;
    else if (opSel != OP_READ)      dataOut = 8'hFF;
    else if (strb.busy)             dataOut = pollByte;
    else if (verifyBlock)           dataOut = 8'hFF;
    else                            dataOut = memRdData;
  end

  // R5: the captured address holds during a busy period
  assert_addr_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(addrQ));

  // R9: no byte write reaches the array once protection bit A is set
  assert_locked_nowrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !lockQ[0]);

  // R8: protection bits only rise except through an erase
  assert_lock_mono_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitErase |=> ((lockQ & $past(lockQ)) == $past(lockQ)));

  // R6: an erase leaves all protection bits clear
  assert_erase_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitErase |=> (lockQ == '0));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progEn,
  input  logic              lvMode,
  input  logic [2:0]        opSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              progStrobe,
  output logic [7:0]        dataOut,
  output logic              readyBusy,
  output logic [2:0]        lockLevel,
  output logic              tableReadBlock,
  output logic              eaLatchEn,
  output logic              extExecBlock,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic [7:0]        memWrData,
  output logic              memWrEn,
  output logic              memEraseAll
);

  fpcStrobe_t strb;
  logic [2:0] lockQ;

  fpc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .progStrobe (progStrobe),
    .progEn     (progEn),
    .opSel      (opSel),
    .progLocked (lockQ[0]),
    .strb       (strb)
  );

  fpc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .opSel       (opSel),
    .lvMode      (lvMode),
    .addr        (addr),
    .dataIn      (dataIn),
    .memRdData   (memRdData),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memWrEn     (memWrEn),
    .memEraseAll (memEraseAll),
    .dataOut     (dataOut),
    .lockQ       (lockQ)
  );

  assign readyBusy      = !strb.busy;
  assign tableReadBlock = lockQ[0];
  assign eaLatchEn      = lockQ[0];
  assign extExecBlock   = &lockQ;

  always_comb begin
    if (&lockQ)                   lockLevel = 3'd4;
    else if (lockQ[0] && lockQ[1]) lockLevel = 3'd3;
    else if (lockQ[0])            lockLevel = 3'd2;
    else                          lockLevel = 3'd1;
  end

  // R1: a write or erase only happens while the busy output is low
  assert_busy_on_commit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memEraseAll) |-> !readyBusy);

endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;

  localparam int AW = 6;
  localparam int W  = 6;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          progEn = 1'b0;
  logic          lvMode = 1'b0;
  logic [2:0]    opSel = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic          progStrobe = 1'b0;
  logic [7:0]    dataOut;
  logic          readyBusy;
  logic [2:0]    lockLevel;
  logic          tableReadBlock, eaLatchEn, extExecBlock;
  logic [AW-1:0] memAddr;
  logic [7:0]    memRdData, memWrData;
  logic          memWrEn, memEraseAll;

  logic [7:0] arr [N];
  logic [7:0] expMem [N];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(W)) u0 (
    .clk(clk), .rstN(rstN), .progEn(progEn), .lvMode(lvMode), .opSel(opSel),
    .addr(addr), .dataIn(dataIn), .progStrobe(progStrobe), .dataOut(dataOut),
    .readyBusy(readyBusy), .lockLevel(lockLevel), .tableReadBlock(tableReadBlock),
    .eaLatchEn(eaLatchEn), .extExecBlock(extExecBlock), .memAddr(memAddr),
    .memRdData(memRdData), .memWrData(memWrData), .memWrEn(memWrEn),
    .memEraseAll(memEraseAll)
  );

  // array model: combinational read, clocked write
  assign memRdData = arr[memAddr];
  initial for (int i = 0; i < N; i++) arr[i] = 8'hFF;
  always @(posedge clk) begin
    if (memEraseAll) for (int i = 0; i < N; i++) arr[i] <= 8'hFF;
    else if (memWrEn) arr[memAddr] <= memWrData;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pulse the strobe, optionally poll, count busy cycles
  task automatic runOp(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                       input int expBusy, input bit poll, input logic [7:0] pollData);
    int n = 0;
    @(negedge clk);
    opSel = op; addr = a; dataIn = d; progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0;
    if (poll) begin opSel = 3'd0; addr = a; end
    while (readyBusy == 1'b0 && n < 100) begin
      #1;
      if (poll) chk(dataOut == {~pollData[7], pollData[6:0]}, "R3 polling byte",
                    dataOut, {~pollData[7], pollData[6:0]});
      n++;
      @(negedge clk);
    end
    chk(n == expBusy, "R1/R5 busy length", n, expBusy);
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    opSel = 3'd0; addr = a;
    #1 chk(dataOut == exp, tag, dataOut, exp);
  endtask

  task automatic sigChk(input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk);
    opSel = 3'd4; addr = a;
    #1 chk(dataOut == exp, "R7 identification byte", dataOut, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) expMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(readyBusy == 1'b1, "R12 ready after reset", readyBusy, 1);
    chk(lockLevel == 3'd1, "R12 level after reset", lockLevel, 1);
    chk(tableReadBlock == 1'b0 && extExecBlock == 1'b0, "R12 lock outputs", extExecBlock, 0);
    readChk(0, 8'hFF, "R12 erased read");

    // R5 strobe with progEn low is ignored
    runOp(3'd1, 5, 8'h00, 0, 0, 0);
    readChk(5, 8'hFF, "R5 progEn low no write");
    progEn = 1'b1;

    // R2/R3/R4 first sweep of every byte
    for (int a = 0; a < N; a++) begin
      logic [7:0] d = 8'((a * 37 + 91) & 8'hFF);
      runOp(3'd1, AW'(a), d, W, 1, d);
      expMem[a] = expMem[a] & d;
      readChk(AW'(a), expMem[a], "R4 read after program");
    end
    // R2 second sweep: AND with the old contents
    for (int a = 0; a < N; a++) begin
      logic [7:0] d = 8'((a * 11 + 3) & 8'hFF);
      runOp(3'd1, AW'(a), d, W, 0, 0);
      expMem[a] = expMem[a] & d;
      readChk(AW'(a), expMem[a], "R2 reprogram ANDs bits");
    end

    // R13 non-read opcodes drive FFH
    for (int op = 1; op < 8; op++) begin
      if (op != 4) begin
        @(negedge clk);
        opSel = 3'(op); addr = 7;
        #1 chk(dataOut == 8'hFF, "R13 idle read on write opcode", dataOut, 8'hFF);
      end
    end

    // R7 identification bytes in both modes
    sigChk(6'h30, 8'h1E);
    sigChk(6'h31, 8'h51);
    sigChk(6'h32, 8'hFF);
    sigChk(6'h33, 8'hFF);
    lvMode = 1'b1;
    sigChk(6'h32, 8'h05);
    lvMode = 1'b0;

    // R6 erase, polling bit 7 reads 0
    runOp(3'd2, 0, 8'h55, W, 1, 8'hFF);
    for (int a = 0; a < N; a++) begin
      expMem[a] = 8'hFF;
      readChk(AW'(a), 8'hFF, "R6 erased byte");
    end

    // R5 strobe in mid-operation is ignored
    @(negedge clk);
    opSel = 3'd1; addr = 10; dataIn = 8'h3C; progStrobe = 1'b1;
    @(negedge clk);
    progStrobe = 1'b0;
    begin
      int n = 1;
      @(negedge clk); n++;
      opSel = 3'd1; addr = 20; dataIn = 8'h00; progStrobe = 1'b1;
      @(negedge clk); n++;
      progStrobe = 1'b0;
      while (readyBusy == 1'b0 && n < 100) begin
        @(negedge clk);
        if (readyBusy == 1'b0) n++;
      end
      chk(n == W, "R5 busy not extended", n, W);
    end
    expMem[10] = 8'h3C;
    readChk(10, 8'h3C, "R5 first write kept");
    readChk(20, 8'hFF, "R5 second strobe not captured");

    // R8 protection bit B alone keeps level 1, index 0 sets nothing
    runOp(3'd3, 6'h00, 0, W, 0, 0);
    chk(lockLevel == 3'd1, "R8 index 0 sets nothing", lockLevel, 1);
    runOp(3'd3, 6'h02, 0, W, 0, 0);
    chk(lockLevel == 3'd1, "R8 bit B alone level 1", lockLevel, 1);
    readChk(10, 8'h3C, "R10 verify open at level 1");

    // R9 level 2
    runOp(3'd3, 6'h01, 0, W, 0, 0);
    chk(lockLevel == 3'd3, "R8 A and B give level 3", lockLevel, 3);
    runOp(3'd2, 0, 0, W, 0, 0);
    chk(lockLevel == 3'd1, "R6 erase clears bits", lockLevel, 1);
    expMem[10] = 8'hFF;
    runOp(3'd1, 10, 8'h81, W, 0, 0);
    runOp(3'd3, 6'h01, 0, W, 0, 0);
    chk(lockLevel == 3'd2, "R8 level 2", lockLevel, 2);
    chk(tableReadBlock && eaLatchEn, "R9 level 2 outputs", tableReadBlock, 1);
    runOp(3'd1, 10, 8'h00, 0, 0, 0);
    readChk(10, 8'h81, "R9 locked program ignored");
    chk(extExecBlock == 1'b0, "R11 not at level 2", extExecBlock, 0);

    // R10 level 3
    runOp(3'd3, 6'h02, 0, W, 0, 0);
    chk(lockLevel == 3'd3, "R8 level 3", lockLevel, 3);
    readChk(10, 8'hFF, "R10 verify blocked");
    sigChk(6'h31, 8'h51);

    // R11 level 4
    runOp(3'd3, 6'h03, 0, W, 0, 0);
    chk(lockLevel == 3'd4, "R8 level 4", lockLevel, 4);
    chk(extExecBlock == 1'b1, "R11 external execution blocked", extExecBlock, 1);

    // R6 erase from level 4 restores everything
    runOp(3'd2, 0, 0, W, 1, 8'hFF);
    chk(lockLevel == 3'd1, "R6 level after erase", lockLevel, 1);
    readChk(10, 8'hFF, "R6 byte erased from level 4");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule